// File: doc/BRIEF.md
# Strip-to-interleave pixel reorder buffer

This block sits between four synchronized video sources and a four-channel panel feed. Each source delivers one vertical strip of the frame: strip `s` carries the STRIP_W columns starting at column `s*STRIP_W`. All four strips deliver one pixel per clock in lockstep. The block re-emits each completed line on one wide output word per clock. Output lane `k` of word `j` holds column `4j+k` of the full line, so lane `k` carries every fourth column, starting at column `k`.

Storage is a two-line ping-pong buffer. Each line is split into one bank per strip, and each bank word holds NUM_CH consecutive pixels. While one line is being written, the line before it is read. Readout of a line starts as soon as all strips have finished it, so latency is one line plus a two-stage read pipeline. A line whose strips do not start and end together, or that does not carry exactly STRIP_W pixels per strip, sets a sticky error flag and is emitted as black. Line starts must be separated by at least one idle cycle, in which every line-valid input is low.

Top module: `strip_interleave_buf`

## Requirements
- R1: For a good line, output word `j` carries full-line column `NUM_CH*j+k` in bits `[k*PIX_W +: PIX_W]` of `out_pix`, where input strip `s` supplies columns `s*STRIP_W` to `s*STRIP_W+STRIP_W-1` in arrival order.
- R2: Call E the first clock edge at which every `in_lv` bit is sampled low after a line. `out_lv` goes high on edge E+2 and stays high for exactly STRIP_W cycles.
- R3: `out_ls` is high only in the first cycle of each output line. `out_fs` is high only in that same cycle, and only when `in_fs` was high in the first cycle of that input line, meaning the first cycle in which any `in_lv` bit is high.
- R4: Whenever `out_lv` is low, `out_pix`, `out_ls` and `out_fs` are zero. A line being received produces no output until it completes.
- R5: Lines separated by a single idle cycle all come out intact and in order, with no mixing of data between the two line buffers.
- R6: If the `in_lv` bits differ in any cycle of a line, that line is still emitted with the R2 timing, but with `out_pix` all zero. `align_err` goes high at edge E.
- R7: If any strip delivers a pixel count other than STRIP_W in a line (fewer or more), the line is emitted black with the R2 timing, and `align_err` goes high at edge E.
- R8: `align_err` stays high until reset. Good lines that follow a bad line are emitted normally.
- R9: Synchronous active-high `rst` clears all outputs, `align_err`, the counters and the buffer toggle. A line received after reset is emitted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_lv | input | NUM_CH | Line-valid, one bit per input strip |
| in_fs | input | 1 | Frame start, sampled in the first active cycle of a line |
| in_pix | input | NUM_CH*PIX_W | One pixel per strip, strip s in bits [s*PIX_W +: PIX_W] |
| out_lv | output | 1 | Output line valid |
| out_ls | output | 1 | Output line-start pulse |
| out_fs | output | 1 | Output frame-start pulse |
| out_pix | output | NUM_CH*PIX_W | Interleaved output word, lane k in bits [k*PIX_W +: PIX_W] |
| align_err | output | 1 | Sticky alignment or length error |

## Verification
The bench drives lines with a single idle cycle between them. A design that read the buffer being written, or swapped buffers at the wrong edge, would show pixels of the next line in the current output. It sends a line with one strip a cycle late, and lines one pixel short and one pixel long. A design that missed these would emit garbage instead of black, or leave the error flag low. A lane-swap or bank-order mistake shows as wrong columns in the every-cycle comparison. The frame marker is placed on only some lines, so a design that raised `out_fs` on every line start is caught. A later good line and a reset confirm that the error flag is sticky and that it clears.

// File: rtl/sib_pkg.sv
package sib_pkg;
   // Index width for a range of n values, never below one bit.
   function automatic int unsigned sib_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sib_strip_pack.sv
module sib_strip_pack import sib_pkg::*; #(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned STRIP_W = 960,
   parameter int unsigned PIX_W   = 30
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              clr,
   input  logic                              lv,
   input  logic [PIX_W-1:0]                  pix,
   output logic [$clog2(STRIP_W+2)-1:0]      cnt,
   output logic                              we,
   output logic [sib_bits(STRIP_W/NUM_CH)-1:0] waddr,
   output logic [NUM_CH*PIX_W-1:0]           wdata
);
   localparam int unsigned WPB = STRIP_W / NUM_CH;
   localparam int unsigned CW  = $clog2(STRIP_W + 2);
   localparam int unsigned AW  = sib_bits(WPB);
   localparam int unsigned IW  = sib_bits(NUM_CH);
   localparam int unsigned PK  = (NUM_CH - 1) * PIX_W;
   localparam logic [CW-1:0] LEN   = CW'(STRIP_W);
   localparam logic [CW-1:0] LIM   = CW'(STRIP_W + 1);
   localparam logic [IW-1:0] LASTI = IW'(NUM_CH - 1);

   logic [CW-1:0] cnt_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] addr_q;
   logic [PK-1:0] pack_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q  <= '0;
         idx_q  <= '0;
         addr_q <= '0;
      end else if (lv) begin
         if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
         if (cnt_q < LEN) begin
            if (idx_q == LASTI) begin
               idx_q  <= '0;
               addr_q <= addr_q + 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   generate
      if (NUM_CH == 2) begin : g_pair
         always_ff @(posedge clk) if (lv) pack_q <= pix;
      end else begin : g_wide
         always_ff @(posedge clk) if (lv) pack_q <= {pix, pack_q[PK-1:PIX_W]};
      end
   endgenerate

   assign cnt   = cnt_q;
   assign we    = lv && (cnt_q < LEN) && (idx_q == LASTI);
   assign waddr = addr_q;
   assign wdata = {pix, pack_q};
endmodule

// File: rtl/sib_bank.sv
module sib_bank import sib_pkg::*; #(
   parameter int unsigned WPB = 240,
   parameter int unsigned DW  = 120
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic                     wbuf,
   input  logic [sib_bits(WPB)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic                     rbuf,
   input  logic [sib_bits(WPB)-1:0] raddr,
   output logic [DW-1:0]            rdata
);
   localparam int unsigned DEPTH = 2 * WPB;
   localparam int unsigned BW    = sib_bits(DEPTH);
   localparam logic [BW-1:0] OFF = BW'(WPB);

   logic [DW-1:0] mem [DEPTH];
   logic [BW-1:0] wa, ra;

   assign wa = wbuf ? OFF + BW'(waddr) : BW'(waddr);
   assign ra = rbuf ? OFF + BW'(raddr) : BW'(raddr);

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wdata;
      rdata <= mem[ra];
   end
endmodule

// File: rtl/sib_readout.sv
module sib_readout import sib_pkg::*; #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned WPB    = 240,
   parameter int unsigned PIX_W  = 30
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 start,
   input  logic                                 start_buf,
   input  logic                                 start_black,
   input  logic                                 start_fs,
   output logic                                 rbuf,
   output logic [sib_bits(WPB)-1:0]             raddr,
   input  logic [NUM_CH-1:0][NUM_CH*PIX_W-1:0]  rdata,
   output logic                                 out_lv,
   output logic                                 out_ls,
   output logic                                 out_fs,
   output logic [NUM_CH*PIX_W-1:0]              out_pix
);
   localparam int unsigned AW = sib_bits(WPB);
   localparam int unsigned IW = sib_bits(NUM_CH);
   localparam logic [AW-1:0] LASTA = AW'(WPB - 1);
   localparam logic [IW-1:0] LASTB = IW'(NUM_CH - 1);

   logic          act, first, black, fs, buf_q;
   logic [IW-1:0] bank;
   logic [AW-1:0] addr;
   logic          p_act, p_first, p_black, p_fs;
   logic [IW-1:0] p_bank;

   // Sequencer: bank-major, word-minor walk over the finished line.
   always_ff @(posedge clk) begin
      if (rst) begin
         act <= 1'b0; first <= 1'b0; black <= 1'b0; fs <= 1'b0;
         buf_q <= 1'b0; bank <= '0; addr <= '0;
      end else if (start) begin
         act <= 1'b1; first <= 1'b1; black <= start_black; fs <= start_fs;
         buf_q <= start_buf; bank <= '0; addr <= '0;
      end else if (act) begin
         first <= 1'b0;
         if (addr == LASTA) begin
            addr <= '0;
            if (bank == LASTB) act <= 1'b0;
            else bank <= bank + 1'b1;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end

   assign rbuf  = buf_q;
   assign raddr = addr;

   // Stage 1 follows the bank read; stage 2 selects and registers the output.
   always_ff @(posedge clk) begin
      if (rst) begin
         p_act <= 1'b0; p_first <= 1'b0; p_black <= 1'b0; p_fs <= 1'b0; p_bank <= '0;
         out_lv <= 1'b0; out_ls <= 1'b0; out_fs <= 1'b0; out_pix <= '0;
      end else begin
         p_act   <= act;
         p_first <= first;
         p_black <= black;
         p_fs    <= fs;
         p_bank  <= bank;
         out_lv  <= p_act;
         out_ls  <= p_act && p_first;
         out_fs  <= p_act && p_first && p_fs;
         out_pix <= (p_act && !p_black) ? rdata[p_bank] : '0;
      end
   end
endmodule

// File: rtl/strip_interleave_buf.sv
module strip_interleave_buf import sib_pkg::*; #(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned STRIP_W = 960,
   parameter int unsigned PIX_W   = 30
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_CH-1:0]         in_lv,
   input  logic                      in_fs,
   input  logic [NUM_CH*PIX_W-1:0]   in_pix,
   output logic                      out_lv,
   output logic                      out_ls,
   output logic                      out_fs,
   output logic [NUM_CH*PIX_W-1:0]   out_pix,
   output logic                      align_err
);
   localparam int unsigned WPB = STRIP_W / NUM_CH;
   localparam int unsigned DW  = NUM_CH * PIX_W;
   localparam int unsigned CW  = $clog2(STRIP_W + 2);
   localparam int unsigned AW  = sib_bits(WPB);
   localparam logic [CW-1:0] LEN = CW'(STRIP_W);

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("NUM_CH must be at least 2");
      end
      if (STRIP_W % NUM_CH != 0) begin : g_bad_w
         $error("STRIP_W must be a multiple of NUM_CH");
      end
      if (WPB < 2) begin : g_bad_wpb
         $error("STRIP_W must hold at least two words per bank");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("PIX_W must be positive");
      end
   endgenerate

   logic [NUM_CH-1:0][CW-1:0] cnt;
   logic [NUM_CH-1:0]         we;
   logic [NUM_CH-1:0][AW-1:0] waddr;
   logic [NUM_CH-1:0][DW-1:0] wdata;
   logic [NUM_CH-1:0][DW-1:0] rdata;
   logic                      rbuf;
   logic [AW-1:0]             raddr;
   logic wsel, lv_any_q, err_acc, fs_acc, err_q;
   logic lv_any, lv_all, line_end, len_bad, bad_line;

   assign lv_any   = |in_lv;
   assign lv_all   = &in_lv;
   assign line_end = lv_any_q && !lv_any;

   always_comb begin
      len_bad = 1'b0;
      for (int s = 0; s < NUM_CH; s++) if (cnt[s] != LEN) len_bad = 1'b1;
   end
   assign bad_line = err_acc || len_bad;

   genvar gs;
   generate
      for (gs = 0; gs < NUM_CH; gs++) begin : g_strip
         sib_strip_pack #(.NUM_CH(NUM_CH), .STRIP_W(STRIP_W), .PIX_W(PIX_W)) u_pack (
            .clk(clk), .rst(rst), .clr(line_end), .lv(in_lv[gs]),
            .pix(in_pix[gs*PIX_W +: PIX_W]), .cnt(cnt[gs]), .we(we[gs]),
            .waddr(waddr[gs]), .wdata(wdata[gs]));
         sib_bank #(.WPB(WPB), .DW(DW)) u_bank (
            .clk(clk), .we(we[gs]), .wbuf(wsel), .waddr(waddr[gs]),
            .wdata(wdata[gs]), .rbuf(rbuf), .raddr(raddr), .rdata(rdata[gs]));
      end
   endgenerate

   // Line control: buffer toggle, per-line error and frame-marker capture.
   always_ff @(posedge clk) begin
      if (rst) begin
         wsel <= 1'b0; lv_any_q <= 1'b0; err_acc <= 1'b0; fs_acc <= 1'b0; err_q <= 1'b0;
      end else begin
         lv_any_q <= lv_any;
         if (line_end) begin
            wsel    <= ~wsel;
            err_acc <= 1'b0;
            fs_acc  <= 1'b0;
            if (bad_line) err_q <= 1'b1;
         end else begin
            if (lv_any && !lv_all) err_acc <= 1'b1;
            if (in_fs && lv_any && !lv_any_q) fs_acc <= 1'b1;
         end
      end
   end

   sib_readout #(.NUM_CH(NUM_CH), .WPB(WPB), .PIX_W(PIX_W)) u_rd (
      .clk(clk), .rst(rst), .start(line_end), .start_buf(wsel),
      .start_black(bad_line), .start_fs(fs_acc), .rbuf(rbuf), .raddr(raddr),
      .rdata(rdata), .out_lv(out_lv), .out_ls(out_ls), .out_fs(out_fs),
      .out_pix(out_pix));

   assign align_err = err_q;
endmodule

// File: rtl/sib_reorder_chk.sv
module sib_reorder_chk #(
   parameter int unsigned DW = 120
) (
   input logic          clk,
   input logic          rst,
   input logic          out_lv,
   input logic          out_ls,
   input logic          out_fs,
   input logic [DW-1:0] out_pix,
   input logic          align_err
);
   AST_LS_IN_LINE: assert property (@(posedge clk) disable iff (rst) out_ls |-> out_lv); // R3
   AST_LS_SINGLE: assert property (@(posedge clk) disable iff (rst) out_ls |=> !out_ls); // R3
   AST_FS_ON_LS: assert property (@(posedge clk) disable iff (rst) out_fs |-> out_ls); // R3
   AST_LS_AT_RISE: assert property (@(posedge clk) disable iff (rst) $rose(out_lv) |-> out_ls); // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !out_lv |-> (out_pix == '0)); // R4
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) align_err |=> align_err); // R8
endmodule

bind strip_interleave_buf sib_reorder_chk #(.DW(NUM_CH*PIX_W)) u_chk (
   .clk(clk), .rst(rst), .out_lv(out_lv), .out_ls(out_ls), .out_fs(out_fs),
   .out_pix(out_pix), .align_err(align_err));

// File: tb/strip_interleave_buf_tb_top.sv
module strip_interleave_buf_tb_top;
   localparam int NC = 4;
   localparam int W  = 16;
   localparam int PW = 30;
   localparam int DW = NC * PW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NC-1:0] in_lv = '0;
   logic in_fs = 1'b0;
   logic [DW-1:0] in_pix = '0;
   logic out_lv, out_ls, out_fs, align_err;
   logic [DW-1:0] out_pix;

   int cyc = 0;
   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;
   bit err_m = 1'b0;

   int    q_e[$];
   int    q_line[$];
   bit    q_bad[$];
   bit    q_fs[$];
   string q_tag[$];

   strip_interleave_buf #(.NUM_CH(NC), .STRIP_W(W), .PIX_W(PW)) dut_i (
      .clk(clk), .rst(rst), .in_lv(in_lv), .in_fs(in_fs), .in_pix(in_pix),
      .out_lv(out_lv), .out_ls(out_ls), .out_fs(out_fs), .out_pix(out_pix),
      .align_err(align_err));

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [PW-1:0] pixv(int line, int col);
      return PW'(line * 4096 + col + 1);
   endfunction

   task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
      end
   endtask

   // Reference model: compares every output on every cycle.
   always @(negedge clk) begin
      if (!rst && !done) begin
         automatic int n = cyc;
         automatic bit e_lv = 1'b0, e_ls = 1'b0, e_fs = 1'b0;
         automatic logic [DW-1:0] e_pix = '0;
         automatic string tag = "R4";
         while (q_e.size() > 0 && n > q_e[0] + W + 1) begin
            void'(q_e.pop_front()); void'(q_line.pop_front());
            void'(q_bad.pop_front()); void'(q_fs.pop_front()); void'(q_tag.pop_front());
         end
         if (q_e.size() > 0) begin
            if (q_bad[0] && n >= q_e[0]) err_m = 1'b1;
            if (n >= q_e[0] + 2) begin
               automatic int k = n - q_e[0] - 2;
               e_lv = 1'b1;
               e_ls = (k == 0);
               e_fs = (k == 0) && q_fs[0];
               tag  = q_tag[0];
               if (!q_bad[0])
                  for (int i = 0; i < NC; i++) e_pix[i*PW +: PW] = pixv(q_line[0], NC*k + i);
            end
         end
         chk(out_lv == e_lv, (e_lv ? "R2" : "R4"), DW'(out_lv), DW'(e_lv));
         chk(out_ls == e_ls, "R3", DW'(out_ls), DW'(e_ls));
         chk(out_fs == e_fs, "R3", DW'(out_fs), DW'(e_fs));
         chk(out_pix == e_pix, tag, out_pix, e_pix);
         chk(align_err == err_m, "R8", DW'(align_err), DW'(err_m));
      end
   end

   // mode 0 good, 1 strip 2 one cycle late, 2 short by one, 3 long by one
   task automatic drive_line(int line, bit fs, int mode, string tag);
      automatic int len  = (mode == 2) ? W - 1 : (mode == 3) ? W + 1 : W;
      automatic int skew = (mode == 1) ? 1 : 0;
      automatic int nl = 0;
      for (int t = 0; t < len + skew; t++) begin
         @(negedge clk);
         for (int s = 0; s < NC; s++) begin
            automatic bit late = (s == 2) && (skew == 1);
            automatic bit act  = late ? (t >= 1 && t < len + 1) : (t < len);
            automatic int p    = late ? t - 1 : t;
            in_lv[s] = act;
            in_pix[s*PW +: PW] = act ? pixv(line, s*W + p) : '0;
         end
         in_fs = fs && (t == 0);
         nl = cyc;
      end
      @(negedge clk);
      in_lv = '0; in_pix = '0; in_fs = 1'b0;
      q_e.push_back(nl + 2); q_line.push_back(line);
      q_bad.push_back(mode != 0); q_fs.push_back(fs); q_tag.push_back(tag);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state
      chk({out_lv, out_ls, out_fs, align_err} == 4'b0 && out_pix == '0, "R9",
          {out_pix[DW-5:0], out_lv, out_ls, out_fs, align_err}, '0);
      rst = 1'b0;
      drive_line(0, 1'b1, 0, "R1");   // R4: no output while this line arrives
      drive_line(1, 1'b0, 0, "R5");   // R5: back-to-back with one idle cycle
      drive_line(2, 1'b0, 0, "R5");
      drive_line(3, 1'b0, 0, "R5");
      idle(5);
      drive_line(4, 1'b1, 0, "R3");
      idle(3);
      drive_line(5, 1'b0, 1, "R6");   // R6: misaligned strip
      drive_line(6, 1'b0, 0, "R8");   // R8: good line after a bad one
      drive_line(7, 1'b0, 2, "R7");   // R7: short line
      drive_line(8, 1'b0, 3, "R7");   // R7: long line
      drive_line(9, 1'b1, 0, "R1");
      idle(2*W + 6);
      chk(align_err == 1'b1, "R8", DW'(align_err), DW'(1));
      rst = 1'b1;
      err_m = 1'b0;
      idle(2);
      chk(align_err == 1'b0 && out_lv == 1'b0 && out_pix == '0, "R9",
          DW'({align_err, out_lv}), '0);
      rst = 1'b0;
      drive_line(10, 1'b1, 0, "R9");
      idle(2*W + 6);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule